// File: doc/BRIEF.md
# Voltage and Frequency Step Sequencer

This block moves a processor's operating point toward a requested performance level. The point has two parts: a supply-voltage index, sent as a digital code to an external regulator, and a clock-frequency index, sent to an external clock generator. Software gives only the frequency index it wants. The block derives the lowest voltage index that can carry that frequency and walks both indices to the goal one unit at a time.

The order of the steps depends on the direction of the move. When speeding up, the voltage climbs before any frequency step. When slowing down, the frequency drops before any voltage step. So the clock never runs faster than the present supply can support. Every voltage step is followed by a fixed settle wait, counted in clock cycles, before the next step. A frequency step lets the next step follow on the very next cycle.

A new request that arrives in the middle of a move is held. It takes effect at the next step decision, after the step in progress has finished. The block shows busy for the whole move and gives a single-cycle done pulse when both indices have reached the goal.

Top module: `dvfs_seq`

## Requirements
- R1: While reset is high and in the cycle after it, vidx_o and fidx_o are 0, and busy and done are low.
- R2: The voltage floor of frequency index f is the smallest voltage index v such that v*(NUM_FLEVELS-1) >= f*(NUM_VLEVELS-1). When a move completes, fidx_o equals the requested index and vidx_o equals its floor.
- R3: When the target frequency is above the current one, vidx_o rises one step at a time up to the target's floor before fidx_o makes any step upward.
- R4: When the target frequency is below the current one, fidx_o falls all the way to the target before vidx_o makes any step downward.
- R5: Each change of the outputs moves exactly one of vidx_o or fidx_o, by exactly one unit.
- R6: In every cycle, vidx_o is at least the voltage floor of fidx_o.
- R7: After a voltage step, the next change of either index comes exactly SETTLE_CYC+1 cycles later. After a frequency step, the next change, if there is one, comes on the following cycle.
- R8: busy rises in the cycle after an idle block accepts req_valid. It stays high until the move completes. done is then high for exactly one cycle, and busy falls in that same cycle.
- R9: A request taken while busy is held. The step in progress finishes, and every later step decision steers toward the newest request.
- R10: A request for the index already in place causes no index change, and done follows one cycle after busy rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_fidx | input | FW | Requested frequency index |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle pulse when the move completes |
| vidx_o | output | VW | Voltage code to the regulator |
| fidx_o | output | FW | Frequency code to the clock generator |

## Verification
The hardest case to reach is a request that lands mid-move, especially one that reverses the direction after the voltage has already started to climb. The stimulus gets there by counting the index changes seen at the ports. Right after a chosen voltage step, while the settle wait is still running, it issues the second request. This makes the cycle in which the held request takes over fully deterministic, so the expected path can be computed in advance. That path runs from the partial climb down through the frequency steps and then the voltage steps.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_DECIDE,
    SQ_SETTLE
  } seq_state_t;

  typedef enum logic [2:0] {
    STEP_NONE,
    STEP_F_UP,
    STEP_F_DN,
    STEP_V_UP,
    STEP_V_DN
  } step_t;

  // lowest voltage index able to carry frequency index fi (rounded up)
  function automatic int unsigned volt_floor(int unsigned fi, int unsigned nf,
                                             int unsigned nv);
    if (nf < 2) return 0;
    return (fi * (nv - 1) + (nf - 2)) / (nf - 1);
  endfunction

endpackage

// File: rtl/dvfs_vfloor_rom.sv
module dvfs_vfloor_rom #(
  parameter int NF = 16,
  parameter int NV = 32,
  parameter int FW = 4,
  parameter int VW = 5
) (
  input  logic [FW-1:0] fidx_i,
  output logic [VW-1:0] vfloor_o
);
  import dvfs_seq_pkg::*;

  logic [VW-1:0] rom [NF];

  for (genvar g = 0; g < NF; g++) begin : g_ent
    assign rom[g] = VW'(volt_floor(g, NF, NV));
  end

  assign vfloor_o = rom[fidx_i];
endmodule

// File: rtl/dvfs_step_planner.sv
module dvfs_step_planner #(
  parameter int FW = 4,
  parameter int VW = 5
) (
  input  logic [VW-1:0]       cur_v,
  input  logic [FW-1:0]       cur_f,
  input  logic [FW-1:0]       tgt_f,
  input  logic [VW-1:0]       tgt_vfloor,
  output dvfs_seq_pkg::step_t step_o
);
  import dvfs_seq_pkg::*;

  always_comb begin
    step_o = STEP_NONE;
    if (cur_f > tgt_f) begin
      step_o = STEP_F_DN;
    end else if (cur_f < tgt_f) begin
      if (cur_v < tgt_vfloor) step_o = STEP_V_UP;
      else                    step_o = STEP_F_UP;
    end else if (cur_v > tgt_vfloor) begin
      step_o = STEP_V_DN;
    end else if (cur_v < tgt_vfloor) begin
      step_o = STEP_V_UP;
    end
  end
endmodule

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic expired_o
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start_i) begin
      cnt <= CW'(SETTLE_CYC - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired_o = run && (cnt == '0);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int NUM_FLEVELS = 16,
  parameter int NUM_VLEVELS = 32,
  parameter int SETTLE_CYC  = 4000000,
  localparam int FW = $clog2(NUM_FLEVELS),
  localparam int VW = $clog2(NUM_VLEVELS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [FW-1:0] req_fidx,
  output logic          busy,
  output logic          done,
  output logic [VW-1:0] vidx_o,
  output logic [FW-1:0] fidx_o
);
  import dvfs_seq_pkg::*;

  seq_state_t    state;
  logic [FW-1:0] tgt_f;
  logic [FW-1:0] pend_f;
  logic          pend_vld;
  logic [FW-1:0] eff_f;
  logic [VW-1:0] eff_floor;
  step_t         step;
  logic          settle_start;
  logic          settle_done;

  assign eff_f = pend_vld ? pend_f : tgt_f;

  dvfs_vfloor_rom #(
    .NF(NUM_FLEVELS), .NV(NUM_VLEVELS), .FW(FW), .VW(VW)
  ) floor_i (
    .fidx_i  (eff_f),
    .vfloor_o(eff_floor)
  );

  dvfs_step_planner #(.FW(FW), .VW(VW)) plan_i (
    .cur_v     (vidx_o),
    .cur_f     (fidx_o),
    .tgt_f     (eff_f),
    .tgt_vfloor(eff_floor),
    .step_o    (step)
  );

  assign settle_start = (state == SQ_DECIDE) &&
                        ((step == STEP_V_UP) || (step == STEP_V_DN));

  dvfs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (settle_start),
    .expired_o(settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      vidx_o   <= '0;
      fidx_o   <= '0;
      tgt_f    <= '0;
      pend_f   <= '0;
      pend_vld <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            tgt_f <= req_fidx;
            busy  <= 1'b1;
            state <= SQ_DECIDE;
          end
        end
        SQ_DECIDE: begin
          tgt_f    <= eff_f;
          pend_vld <= 1'b0;
          case (step)
            STEP_F_UP: fidx_o <= fidx_o + 1'b1;
            STEP_F_DN: fidx_o <= fidx_o - 1'b1;
            STEP_V_UP: begin
              vidx_o <= vidx_o + 1'b1;
              state  <= SQ_SETTLE;
            end
            STEP_V_DN: begin
              vidx_o <= vidx_o - 1'b1;
              state  <= SQ_SETTLE;
            end
            default: begin
              if (!req_valid) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                state <= SQ_IDLE;
              end
            end
          endcase
        end
        SQ_SETTLE: begin
          if (settle_done) state <= SQ_DECIDE;
        end
        default: state <= SQ_IDLE;
      endcase
      if (req_valid && (state != SQ_IDLE)) begin
        pend_f   <= req_fidx;
        pend_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int NUM_FLEVELS = 16,
  parameter int NUM_VLEVELS = 32,
  parameter int SETTLE_CYC  = 16,
  parameter int FW = 4,
  parameter int VW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [VW-1:0] vidx,
  input logic [FW-1:0] fidx
);
  logic          rst_q;
  logic [VW-1:0] vq;
  logic [FW-1:0] fq;
  logic          last_v;
  int unsigned   gap;
  logic          vchg;
  logic          fchg;

  assign vchg = (vidx != vq);
  assign fchg = (fidx != fq);

  always_ff @(posedge clk) begin
    rst_q <= rst;
    vq    <= vidx;
    fq    <= fidx;
    if (rst) begin
      last_v <= 1'b0;
      gap    <= 0;
    end else if (vchg || fchg) begin
      last_v <= vchg;
      gap    <= 0;
    end else if (gap < SETTLE_CYC) begin
      gap <= gap + 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_STATE: assert (vidx == '0 && fidx == '0 && !busy && !done); // R1
    end
  end

  AST_SINGLE_V_STEP: assert property (@(posedge clk) disable iff (rst)
    (vidx != $past(vidx)) |-> (fidx == $past(fidx)) &&
      ((32'(vidx) == 32'($past(vidx)) + 1) || (32'(vidx) + 1 == 32'($past(vidx))))); // R5

  AST_SINGLE_F_STEP: assert property (@(posedge clk) disable iff (rst)
    (fidx != $past(fidx)) |-> (vidx == $past(vidx)) &&
      ((32'(fidx) == 32'($past(fidx)) + 1) || (32'(fidx) + 1 == 32'($past(fidx))))); // R5

  AST_FLOOR_HELD: assert property (@(posedge clk) disable iff (rst)
    int'(vidx) * (NUM_FLEVELS - 1) >= int'(fidx) * (NUM_VLEVELS - 1)); // R6

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
    ((vchg || fchg) && last_v) |-> (gap >= SETTLE_CYC)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
endmodule

bind dvfs_seq dvfs_seq_chk #(
  .NUM_FLEVELS(NUM_FLEVELS), .NUM_VLEVELS(NUM_VLEVELS),
  .SETTLE_CYC(SETTLE_CYC), .FW(FW), .VW(VW)
) chk_i (
  .clk (clk),
  .rst (rst),
  .busy(busy),
  .done(done),
  .vidx(vidx_o),
  .fidx(fidx_o)
);

// File: tb/dvfs_seq_tb_top.sv
`timescale 1ns/1ps
module dvfs_seq_tb_top;
  localparam int NF = 16;
  localparam int NV = 32;
  localparam int SC = 6;
  localparam int FW = 4;
  localparam int VW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [FW-1:0] req_fidx = '0;
  logic          busy;
  logic          done;
  logic [VW-1:0] vidx;
  logic [FW-1:0] fidx;

  always #2.5 clk = ~clk;

  dvfs_seq #(.NUM_FLEVELS(NF), .NUM_VLEVELS(NV), .SETTLE_CYC(SC)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fidx(req_fidx),
    .busy(busy), .done(done), .vidx_o(vidx), .fidx_o(fidx)
  );

  typedef struct {
    int    v;
    int    f;
    int    gap;
    string rq;
  } exp_t;

  exp_t  q[$];
  int    total = 0;
  int    bad = 0;
  int    chg_cnt = 0;
  int    mv = 0;
  int    mf = 0;
  bit    ended = 1'b0;

  // smallest voltage index whose product meets the frequency's (R2)
  function automatic int bfloor(int f);
    for (int v = 0; v < NV; v++)
      if (v * (NF - 1) >= f * (NV - 1)) return v;
    return NV - 1;
  endfunction

  task automatic check_eq(string rq, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // driver side: expected step list, target switches to tb after k steps
  task automatic plan(int ta, int k, int tb, string rq);
    int  n = 0;
    bit  fin = 1'b0;
    bit  lastv = 1'b0;
    bit  isv;
    int  t;
    int  fl;
    while (!fin) begin
      t  = (k > 0 && n >= k) ? tb : ta;
      fl = bfloor(t);
      isv = 1'b0;
      if (mf > t) mf--;
      else if (mf < t) begin
        if (mv < fl) begin mv++; isv = 1'b1; end
        else mf++;
      end else if (mv > fl) begin mv--; isv = 1'b1; end
      else if (mv < fl) begin mv++; isv = 1'b1; end
      else fin = 1'b1;
      if (!fin) begin
        q.push_back('{mv, mf, (n == 0) ? 0 : (lastv ? SC + 1 : 1), rq});
        lastv = isv;
        n++;
      end
    end
  endtask

  // monitor: pops one expected item per observed index change
  initial begin
    logic [VW-1:0] pv;
    logic [FW-1:0] pf;
    int            gc;
    exp_t          e;
    pv = '0; pf = '0; gc = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        pv = vidx; pf = fidx; gc = 0;
        continue;
      end
      if (vidx !== pv || fidx !== pf) begin
        chg_cnt++;
        check_eq("R6", "vidx meets floor", int'(int'(vidx) >= bfloor(int'(fidx))), 1);
        if (q.size() == 0) begin
          check_eq("R5", "unexpected change vidx", int'(vidx), int'(pv));
        end else begin
          e = q.pop_front();
          check_eq(e.rq, "vidx", int'(vidx), e.v);
          check_eq(e.rq, "fidx", int'(fidx), e.f);
          if (e.gap != 0) check_eq("R7", "cycles between changes", gc + 1, e.gap);
        end
        pv = vidx; pf = fidx; gc = 0;
      end else begin
        gc++;
      end
    end
  end

  task automatic run(int ta, int k, int tb, string rq, output int lat);
    int fin_t;
    fin_t = (k > 0) ? tb : ta;
    chg_cnt = 0;
    plan(ta, k, tb, rq);
    @(negedge clk);
    req_valid = 1'b1;
    req_fidx  = FW'(ta);
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R8", "busy after accept", int'(busy), 1);
    if (k > 0) begin
      wait (chg_cnt == k);
      @(negedge clk);
      req_valid = 1'b1;
      req_fidx  = FW'(tb);
      @(negedge clk);
      req_valid = 1'b0;
    end
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
    check_eq("R8", "busy at done", int'(busy), 0);
    check_eq(rq, "steps left over", q.size(), 0);
    check_eq("R2", "final fidx", int'(fidx), fin_t);
    check_eq("R2", "final vidx", int'(vidx), bfloor(fin_t));
    @(negedge clk);
    check_eq("R8", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check_eq("R1", "vidx in reset", int'(vidx), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "vidx", int'(vidx), 0);
    check_eq("R1", "fidx", int'(fidx), 0);
    check_eq("R1", "busy", int'(busy), 0);
    check_eq("R1", "done", int'(done), 0);

    run(7, 0, 0, "R3", lat);    // climb from rest
    run(15, 0, 0, "R3", lat);   // climb to the top
    run(3, 0, 0, "R4", lat);    // long descent
    run(3, 0, 0, "R10", lat);   // same level again
    check_eq("R10", "done latency", lat, 1);
    run(10, 2, 5, "R9", lat);   // retarget lower while climbing
    run(12, 3, 2, "R9", lat);   // reverse direction mid-climb
    run(0, 0, 0, "R4", lat);    // back to rest

    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule